// File: doc/BRIEF.md
# Dual-Domain Clock Gear Controller

This block turns one oscillator-rate clock into two enable strobes, one for a processor domain and one for a peripheral domain. Each strobe is high for one input cycle at a power-of-two fraction of a shared base rate, so the logic it feeds runs from the oscillator clock and only advances when its strobe is high. It produces no derived or gated clocks.

Software sets the gear through one 8-bit register, written a whole byte at a time and always readable. One field gears the processor strobe and another gears the peripheral strobe, and the two fields are independent. A single select bit makes the base rate either the oscillator rate or half of it. Because both dividers count the same base enable, changing that bit changes both domains in the same cycle. A small state machine makes the base enable. Its states are `BS_DIRECT` (base enable every cycle), `BS_HALF_IDLE` (base enable off) and `BS_HALF_FIRE` (base enable on). The halved-mode states alternate `BS_HALF_IDLE -> BS_HALF_FIRE -> BS_HALF_IDLE`. When the select bit disagrees with the state, the transition `resync` takes place: it goes to `BS_HALF_IDLE` when the bit is 1 and to `BS_DIRECT` when it is 0. In that cycle no base enable is given and both divider counters are cleared.

Top module: `gear_clk_ctrl`

## Requirements
- R1: After reset the register reads 8'hFE, and both strobes pulse once every 8 input cycles.
- R2: When `wr_en` is high at a clock edge, `wr_data` is stored whole and `rd_data` shows it from the next cycle. Without a write, `rd_data` holds its value.
- R3: Register bits 7:6 gear the processor strobe. Codes 00, 01, 10 and 11 give a pulse on every 1st, 2nd, 4th or 8th base enable.
- R4: Register bits 3:2 gear the peripheral strobe with the same codes, independently of bits 7:6.
- R5: Register bit 0 picks the base. At 0 the base enable is high every input cycle. At 1 it is high every second input cycle, which doubles the pulse spacing of both strobes. In halved mode, a strobe pulse is always followed by a cycle in which neither strobe pulses.
- R6: Register bits 5:4 and bit 1 read back as written and do not change the spacing of either strobe.
- R7: A new gear code is taken up only when the running count wraps. The interval in progress ends at its old length, so no pulse is shortened or duplicated, and the next interval has the new length.
- R8: In the cycle after a write flips bit 0, neither strobe pulses, and both counters restart from zero together. In halved mode a strobe geared /N therefore first pulses on the 2N-th cycle after the one in which bit 0 changed, and the slower strobe's pulses coincide with pulses of the faster one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe for the gear register |
| wr_data | input | 8 | Byte to store in the gear register |
| rd_data | output | 8 | Current gear register contents |
| cpu_en | output | 1 | One-cycle enable strobe for the processor domain |
| per_en | output | 1 | One-cycle enable strobe for the peripheral domain |

## Verification
The hardest situations to reach from the ports are a gear write that lands in the same cycle as a counter wrap, and a source flip while the two counters are out of phase. The bench waits for a processor pulse and issues the write at that exact edge. It then times the following interval, which must keep the old length, and the one after it, which takes the new length. For the flip, it first runs the two domains at different ratios so that their phases differ. It then flips bit 0 and counts cycles from the write to the first pulse of each strobe.

// File: rtl/gear_pkg.sv
package gear_pkg;

    // Base-enable sequencer states
    typedef enum logic [1:0] {
        BS_DIRECT    = 2'd0,
        BS_HALF_IDLE = 2'd1,
        BS_HALF_FIRE = 2'd2
    } base_state_t;

    localparam int GEAR_W = 2;                       // width of one gear code
    localparam int CNT_W  = (1 << GEAR_W) - 1;       // counter width to reach the largest ratio
    localparam int N_DOM  = 2;                       // processor, peripheral

    // Last count value before wrap for a given gear code: 2**code - 1
    function automatic logic [CNT_W-1:0] wrap_value(input logic [GEAR_W-1:0] code);
        logic [CNT_W:0] one_hot;
        one_hot = '0;
        one_hot[code] = 1'b1;
        return CNT_W'(one_hot - 1'b1);
    endfunction

endpackage

// File: rtl/gear_reg.sv
module gear_reg #(
    parameter int          REG_W   = 8,
    parameter logic [7:0]  RST_VAL = 8'hFE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] value
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= REG_W'(RST_VAL);
        end else if (wr_en) begin
            value <= wr_data;
        end
    end

endmodule

// File: rtl/base_seq.sv
module base_seq
    import gear_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_half,
    output logic base_en,
    output logic resync
);

    base_state_t state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BS_DIRECT;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            BS_DIRECT:    state_nx = src_half ? BS_HALF_IDLE : BS_DIRECT;
            BS_HALF_IDLE: state_nx = src_half ? BS_HALF_FIRE : BS_DIRECT;
            BS_HALF_FIRE: state_nx = src_half ? BS_HALF_IDLE : BS_DIRECT;
            default:      state_nx = BS_DIRECT;
        endcase
    end

    // outputs
    always_comb begin
        base_en = 1'b0;
        resync  = 1'b0;
        unique case (state)
            BS_DIRECT: begin
                resync  = src_half;
                base_en = !src_half;
            end
            BS_HALF_IDLE: begin
                resync  = !src_half;
            end
            BS_HALF_FIRE: begin
                resync  = !src_half;
                base_en = src_half;
            end
            default: begin
                resync  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dom_div.sv
module dom_div
    import gear_pkg::*;
#(
    parameter logic [GEAR_W-1:0] RST_CODE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_en,
    input  logic              resync,
    input  logic [GEAR_W-1:0] code,
    output logic              en_out
);

    logic [CNT_W-1:0]  cnt;
    logic [GEAR_W-1:0] code_q;
    logic              at_wrap;

    assign at_wrap = (cnt == wrap_value(code_q));
    assign en_out  = base_en && at_wrap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            code_q <= RST_CODE;
        end else if (resync) begin
            cnt    <= '0;
            code_q <= code;
        end else if (base_en) begin
            if (at_wrap) begin
                cnt    <= '0;
                code_q <= code;
            end else begin
                cnt    <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/gear_clk_ctrl.sv
module gear_clk_ctrl
    import gear_pkg::*;
#(
    parameter int         REG_W   = 8,
    parameter int         CPU_LSB = 6,
    parameter int         PER_LSB = 2,
    parameter int         SRC_BIT = 0,
    parameter logic [7:0] RST_VAL = 8'hFE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             cpu_en,
    output logic             per_en
);

    localparam int FIELD_LSB [N_DOM] = '{CPU_LSB, PER_LSB};

    logic [REG_W-1:0] gear_q;
    logic             base_en;
    logic             resync;
    logic [N_DOM-1:0] dom_en;

    gear_reg #(.REG_W(REG_W), .RST_VAL(RST_VAL)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .value   (gear_q)
    );

    base_seq u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_half (gear_q[SRC_BIT]),
        .base_en  (base_en),
        .resync   (resync)
    );

    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        localparam int LSB = FIELD_LSB[d];
        dom_div #(.RST_CODE(RST_VAL[LSB +: GEAR_W])) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .base_en (base_en),
            .resync  (resync),
            .code    (gear_q[LSB +: GEAR_W]),
            .en_out  (dom_en[d])
        );
    end

    assign rd_data = gear_q;
    assign cpu_en  = dom_en[0];
    assign per_en  = dom_en[1];

endmodule

// File: rtl/gear_clk_chk.sv
module gear_clk_chk #(
    parameter int REG_W   = 8,
    parameter int CPU_LSB = 6,
    parameter int SRC_BIT = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             cpu_en,
    input logic             per_en
);

    assert_wr_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == $past(wr_data));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));

    assert_full_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en && !wr_en && rd_data[CPU_LSB +: 2] == 2'b00 && !rd_data[SRC_BIT]) |=> cpu_en);

    assert_half_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_en || per_en) && rd_data[SRC_BIT] && !wr_en) |=> (!cpu_en && !per_en));

    assert_resync_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[SRC_BIT] != rd_data[SRC_BIT])) |=> (!cpu_en && !per_en));

endmodule

bind gear_clk_ctrl gear_clk_chk #(.REG_W(REG_W), .CPU_LSB(CPU_LSB), .SRC_BIT(SRC_BIT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .cpu_en  (cpu_en),
    .per_en  (per_en)
);

// File: tb/sim_gear_clk_ctrl.sv
`timescale 1ns/1ps
module sim_gear_clk_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       cpu_en, per_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gear_clk_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .cpu_en(cpu_en), .per_en(per_en)
    );

    // vector: {config byte, expected cpu spacing, expected peripheral spacing}
    localparam int NV = 10;
    localparam logic [23:0] VEC [NV] = '{
        {8'hFE, 8'd8, 8'd8},
        {8'h7A, 8'd2, 8'd4},
        {8'h3A, 8'd1, 8'd4},
        {8'h32, 8'd1, 8'd1},
        {8'hB2, 8'd4, 8'd1},
        {8'h71, 8'd4, 8'd2},
        {8'h33, 8'd2, 8'd2},
        {8'h8E, 8'd4, 8'd8},
        {8'hBC, 8'd4, 8'd8},   // R6: other unused-bit pattern, same spacing
        {8'h4D, 8'd4, 8'd16}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Measures pulse spacing over a window; -1 if spacing varies or too few pulses
    task automatic measure(output int gc, output int gp);
        int lc = -1, lp = -1;
        bit badc = 0, badp = 0;
        gc = -1;
        gp = -1;
        repeat (40) @(negedge clk);
        for (int cyc = 0; cyc < 90; cyc++) begin
            @(negedge clk);
            if (cpu_en) begin
                if (lc >= 0) begin
                    if (gc >= 0 && gc != cyc - lc) badc = 1;
                    gc = cyc - lc;
                end
                lc = cyc;
            end
            if (per_en) begin
                if (lp >= 0) begin
                    if (gp >= 0 && gp != cyc - lp) badp = 1;
                    gp = cyc - lp;
                end
                lp = cyc;
            end
        end
        if (badc) gc = -1;
        if (badp) gp = -1;
    endtask

    initial begin
        int gc, gp;
        int t_c, t_p, first_c, first_p;
        bit coinc;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check("R1 reset value", int'(rd_data), 8'hFE);
        measure(gc, gp);
        check("R1 cpu spacing after reset", gc, 8);
        check("R1 per spacing after reset", gp, 8);

        // table walk
        for (int i = 0; i < NV; i++) begin
            write_reg(VEC[i][23:16]);
            check("R2 readback", int'(rd_data), int'(VEC[i][23:16]));
            measure(gc, gp);
            check("R3/R5/R6 cpu spacing", gc, int'(VEC[i][15:8]));
            check("R4/R5/R6 per spacing", gp, int'(VEC[i][7:0]));
        end

        // full sweep of gear codes and source bit, unused bits varied
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 4; c++) begin
                for (int p = 0; p < 4; p++) begin
                    logic [7:0] b;
                    b = {2'(c), 2'(p + c), 2'(p), 1'(c), 1'(s)};
                    write_reg(b);
                    check("R2 sweep readback", int'(rd_data), int'(b));
                    measure(gc, gp);
                    check("R3 sweep cpu spacing", gc, (1 << c) * (s + 1));
                    check("R4 sweep per spacing", gp, (1 << p) * (s + 1));
                end
            end
        end

        // R7: ratio change written at the wrap edge
        write_reg(8'hFE);
        repeat (40) @(negedge clk);
        t_c = 0;
        while (!cpu_en && t_c < 40) begin
            @(negedge clk);
            t_c++;
        end
        wr_en = 1'b1;
        wr_data = 8'h32;
        @(negedge clk);
        wr_en = 1'b0;
        t_c = 1;
        while (!cpu_en && t_c < 40) begin
            @(negedge clk);
            t_c++;
        end
        check("R7 interval in progress keeps old length", t_c, 8);
        @(negedge clk);
        check("R7 next interval uses new length", int'(cpu_en), 1);

        // R8: source flip realigns both counters
        write_reg(8'h0C);           // cpu /1, per /8, direct
        repeat (37) @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'h0D;            // set source bit
        first_c = -1;
        first_p = -1;
        coinc = 1;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (k == 1) begin
                check("R8 no cpu pulse in resync cycle", int'(cpu_en), 0);
                check("R8 no per pulse in resync cycle", int'(per_en), 0);
            end
            if (cpu_en && first_c < 0) first_c = k;
            if (per_en && first_p < 0) first_p = k;
            if (per_en && !cpu_en) coinc = 0;
        end
        t_p = first_p;
        check("R8 first cpu pulse after flip", first_c, 3);
        check("R8 first per pulse after flip", t_p, 17);
        check("R8 per pulses coincide with cpu", int'(coinc), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule